// File: doc/BRIEF.md
# Clause Issue Sequencer

This block sits between an instruction fetch stage and a scalar execution unit. It takes whole clauses. A clause is a short run of fixed-latency instructions, optionally closed by one memory operation whose latency is not known in advance. Each clause arrives with a header holding a wait mask, a length, per-instruction variable-latency flags and a tracking slot number. Dependencies are settled once, before the first instruction of a clause. While any slot named in the wait mask still has a memory operation in flight, the clause is held. Once released, every fixed-latency instruction goes to the execution unit on consecutive cycles, and no other clause can get in between.

Results of a clause become architecturally visible together. A single commit strobe tells the register file to apply its buffered writes. When a clause ends in a memory operation, that operation is sent on a separate request port after the commit. It marks its slot busy until a completion tag for that slot comes back. A header that places a variable-latency operation anywhere but last, or that has no instructions, is rejected with an error pulse and never issued.

Top module: `clause_seq`

## Requirements
- R1: Out of reset the block is ready for a clause and drives no issue, commit, memory request or error.
- R2: A clause is accepted on a clock edge where `cl_valid_i` and `cl_ready_o` are both high. `cl_ready_o` is high only while no clause is in progress. When no slot in the wait mask is busy, the first instruction appears on the issue port in the cycle right after acceptance.
- R3: Instruction i of a clause is taken from `cl_instr_i[i*INSTR_W +: INSTR_W]`. The fixed-latency instructions issue in order from position 0 upward, one per cycle, with no gap. `cl_ready_o` stays low until the clause ends, so no other clause is interleaved.
- R4: Bit k of `cl_wait_i` refers to slot k. A clause is held before its first instruction while any named slot is busy. Bits naming idle slots cause no delay. A completion for a slot outside the mask does not release the clause.
- R5: A completion (`cmp_valid_i` with binary slot `cmp_slot_i`) that frees the last blocking slot releases the clause in the same cycle: the first instruction issues in that cycle.
- R6: Each accepted clause gives exactly one single-cycle `commit_o` pulse. It comes in the cycle after the last fixed-latency instruction, or in the cycle after release for a clause that has only a memory operation. The pulse never shares a cycle with an issue or a memory request.
- R7: Bit i of `cl_varlat_i` marks instruction i as variable latency. When bit len-1 is set, that instruction is presented on the memory request port in the cycle after the commit, together with the header slot `cl_mem_slot_i`. The request is held while `mem_req_ready_i` is low. When accepted, it marks that slot busy.
- R8: A memory request whose slot is still busy is held back. Its valid rises in the cycle after the completion for that slot.
- R9: A header with length 0, or with a variable-latency flag at any position below len-1, gives a one-cycle `cl_err_o` in the cycle after acceptance. Nothing is issued, committed or requested, and the block is ready again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cl_valid_i | input | 1 | Clause offered |
| cl_ready_o | output | 1 | Sequencer idle, clause can be taken |
| cl_wait_i | input | NSLOT | Wait mask, bit k = slot k |
| cl_len_i | input | LEN_W | Number of instructions in the clause |
| cl_varlat_i | input | MAX_LEN | Variable-latency flag per instruction position |
| cl_mem_slot_i | input | SLOT_W | Slot used by a terminating memory operation |
| cl_instr_i | input | MAX_LEN*INSTR_W | Instruction words, position 0 in the low bits |
| iss_valid_o | output | 1 | Instruction valid on the issue port |
| iss_instr_o | output | INSTR_W | Instruction to the execution unit |
| commit_o | output | 1 | Apply the clause's buffered register writes |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory side accepts the request |
| mem_req_instr_o | output | INSTR_W | Memory instruction word |
| mem_req_slot_o | output | SLOT_W | Slot the request occupies |
| cmp_valid_i | input | 1 | Completion tag valid |
| cmp_slot_i | input | SLOT_W | Slot of the completed operation |
| cl_err_o | output | 1 | Malformed clause rejected |

## Verification
Clauses are sent with an empty wait mask, to measure the fixed one-cycle start and the back-to-back issue order. Another clause waits on a busy slot whose completion arrives some cycles later; this separates a same-cycle release from a release one cycle late. A mask naming only an idle slot, and a completion for an unrelated slot, show whether the wait is tied to the right slot bits. Memory-only clauses are run under request backpressure and on a slot that is still busy, and malformed headers test rejection and the quick return to ready.

// File: rtl/clause_seq_pkg.sv
`timescale 1ns/1ps
package clause_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_ISSUE,
      ST_COMMIT,
      ST_MEMREQ
   } seq_state_e;
endpackage

// File: rtl/clause_hdr_check.sv
`timescale 1ns/1ps
// Decodes a clause header: legality, terminating memory op, fixed count.
module clause_hdr_check #(
   parameter int MAX_LEN = 8,
   parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic [LEN_W-1:0]   len_i,
   input  logic [MAX_LEN-1:0] varlat_i,
   output logic               bad_o,
   output logic               has_mem_o,
   output logic [LEN_W-1:0]   nfix_o
);
   always_comb begin
      bad_o     = (len_i == '0) || (int'(len_i) > MAX_LEN);
      has_mem_o = 1'b0;
      for (int i = 0; i < MAX_LEN; i++) begin
         if (((i + 1) < int'(len_i)) && varlat_i[i]) begin
            bad_o = 1'b1;
         end
         if ((i + 1) == int'(len_i)) begin
            has_mem_o = varlat_i[i];
         end
      end
      nfix_o = len_i - LEN_W'(has_mem_o);
   end
endmodule

// File: rtl/clause_slot_tracker.sv
`timescale 1ns/1ps
// Busy bits for in-flight variable-latency operations.
module clause_slot_tracker #(
   parameter int NSLOT              = 4,
   parameter int SLOT_W             = $clog2(NSLOT),
   parameter bit SAME_CYCLE_RELEASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic [SLOT_W-1:0] set_slot_i,
   input  logic              clr_i,
   input  logic [SLOT_W-1:0] clr_slot_i,
   input  logic [NSLOT-1:0]  wait_mask_i,
   output logic [NSLOT-1:0]  busy_o,
   output logic              blocked_o
);
   logic [NSLOT-1:0] busy_q;
   logic [NSLOT-1:0] set_hot;
   logic [NSLOT-1:0] clr_hot;
   logic [NSLOT-1:0] eff_busy;

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      assign set_hot[k] = set_i && (set_slot_i == SLOT_W'(k));
      assign clr_hot[k] = clr_i && (clr_slot_i == SLOT_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q[k] <= 1'b0;
         end else if (set_hot[k]) begin
            busy_q[k] <= 1'b1;
         end else if (clr_hot[k]) begin
            busy_q[k] <= 1'b0;
         end
      end
   end

   if (SAME_CYCLE_RELEASE) begin : g_fast_rel
      assign eff_busy = busy_q & ~clr_hot;
   end else begin : g_slow_rel
      assign eff_busy = busy_q;
   end

   assign busy_o    = busy_q;
   assign blocked_o = |(wait_mask_i & eff_busy);
endmodule

// File: rtl/clause_seq.sv
`timescale 1ns/1ps
module clause_seq
   import clause_seq_pkg::*;
#(
   parameter int NSLOT              = 4,
   parameter int MAX_LEN            = 8,
   parameter int INSTR_W            = 32,
   parameter bit SAME_CYCLE_RELEASE = 1'b1,
   localparam int SLOT_W = $clog2(NSLOT),
   localparam int LEN_W  = $clog2(MAX_LEN + 1),
   localparam int IDX_W  = $clog2(MAX_LEN)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cl_valid_i,
   output logic                       cl_ready_o,
   input  logic [NSLOT-1:0]           cl_wait_i,
   input  logic [LEN_W-1:0]           cl_len_i,
   input  logic [MAX_LEN-1:0]         cl_varlat_i,
   input  logic [SLOT_W-1:0]          cl_mem_slot_i,
   input  logic [MAX_LEN*INSTR_W-1:0] cl_instr_i,
   output logic                       iss_valid_o,
   output logic [INSTR_W-1:0]         iss_instr_o,
   output logic                       commit_o,
   output logic                       mem_req_valid_o,
   input  logic                       mem_req_ready_i,
   output logic [INSTR_W-1:0]         mem_req_instr_o,
   output logic [SLOT_W-1:0]          mem_req_slot_o,
   input  logic                       cmp_valid_i,
   input  logic [SLOT_W-1:0]          cmp_slot_i,
   output logic                       cl_err_o
);
   if (NSLOT < 2 || (1 << SLOT_W) != NSLOT) begin : g_bad_nslot
      $error("NSLOT must be a power of two of at least 2");
   end
   if (MAX_LEN < 2 || (1 << IDX_W) != MAX_LEN) begin : g_bad_len
      $error("MAX_LEN must be a power of two of at least 2");
   end
   if (INSTR_W < 1) begin : g_bad_w
      $error("INSTR_W must be positive");
   end

   seq_state_e         state_q, state_d;
   logic [IDX_W-1:0]   idx_q, idx_d;
   logic [LEN_W-1:0]   nfix_q;
   logic               has_mem_q;
   logic [SLOT_W-1:0]  mslot_q;
   logic [NSLOT-1:0]   wait_q;
   logic               err_q;
   logic [INSTR_W-1:0] instr_q [MAX_LEN];

   logic               hdr_bad;
   logic               hdr_has_mem;
   logic [LEN_W-1:0]   hdr_nfix;
   logic [NSLOT-1:0]   slot_busy;
   logic               blocked;
   logic               accept;
   logic               last_fix;
   logic               set_busy;
   logic               iss_v, com, memv;
   logic [IDX_W-1:0]   mem_idx;

   clause_hdr_check #(
      .MAX_LEN (MAX_LEN),
      .LEN_W   (LEN_W)
   ) u_hdr (
      .len_i     (cl_len_i),
      .varlat_i  (cl_varlat_i),
      .bad_o     (hdr_bad),
      .has_mem_o (hdr_has_mem),
      .nfix_o    (hdr_nfix)
   );

   clause_slot_tracker #(
      .NSLOT              (NSLOT),
      .SLOT_W             (SLOT_W),
      .SAME_CYCLE_RELEASE (SAME_CYCLE_RELEASE)
   ) u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (set_busy),
      .set_slot_i  (mslot_q),
      .clr_i       (cmp_valid_i),
      .clr_slot_i  (cmp_slot_i),
      .wait_mask_i (wait_q),
      .busy_o      (slot_busy),
      .blocked_o   (blocked)
   );

   assign accept   = (state_q == ST_IDLE) && cl_valid_i;
   assign last_fix = (LEN_W'(idx_q) == (nfix_q - LEN_W'(1)));
   assign mem_idx  = IDX_W'(nfix_q);

   always_comb begin
      state_d  = state_q;
      idx_d    = idx_q;
      iss_v    = 1'b0;
      com      = 1'b0;
      memv     = 1'b0;
      set_busy = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept && !hdr_bad) begin
               state_d = ST_WAIT;
               idx_d   = '0;
            end
         end
         ST_WAIT: begin
            if (!blocked) begin
               if (nfix_q == '0) begin
                  state_d = ST_COMMIT;
               end else begin
                  iss_v   = 1'b1;
                  idx_d   = idx_q + IDX_W'(1);
                  state_d = (nfix_q == LEN_W'(1)) ? ST_COMMIT : ST_ISSUE;
               end
            end
         end
         ST_ISSUE: begin
            iss_v = 1'b1;
            idx_d = idx_q + IDX_W'(1);
            if (last_fix) begin
               state_d = ST_COMMIT;
            end
         end
         ST_COMMIT: begin
            com     = 1'b1;
            state_d = has_mem_q ? ST_MEMREQ : ST_IDLE;
         end
         ST_MEMREQ: begin
            memv = !slot_busy[mslot_q];
            if (memv && mem_req_ready_i) begin
               set_busy = 1'b1;
               state_d  = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         idx_q     <= '0;
         nfix_q    <= '0;
         has_mem_q <= 1'b0;
         mslot_q   <= '0;
         wait_q    <= '0;
         err_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         err_q   <= accept && hdr_bad;
         if (accept && !hdr_bad) begin
            nfix_q    <= hdr_nfix;
            has_mem_q <= hdr_has_mem;
            mslot_q   <= cl_mem_slot_i;
            wait_q    <= cl_wait_i;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept && !hdr_bad) begin
         for (int i = 0; i < MAX_LEN; i++) begin
            instr_q[i] <= cl_instr_i[i*INSTR_W +: INSTR_W];
         end
      end
   end

   assign cl_ready_o      = (state_q == ST_IDLE);
   assign iss_valid_o     = iss_v;
   assign iss_instr_o     = instr_q[idx_q];
   assign commit_o        = com;
   assign mem_req_valid_o = memv;
   assign mem_req_instr_o = instr_q[mem_idx];
   assign mem_req_slot_o  = mslot_q;
   assign cl_err_o        = err_q;
endmodule

// File: rtl/clause_seq_chk.sv
`timescale 1ns/1ps
module clause_seq_chk #(
   parameter int NSLOT  = 4,
   parameter int SLOT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cl_ready_o,
   input logic              iss_valid_o,
   input logic              commit_o,
   input logic              mem_req_valid_o,
   input logic              mem_req_ready_i,
   input logic [SLOT_W-1:0] mem_req_slot_o,
   input logic              cmp_valid_i,
   input logic [SLOT_W-1:0] cmp_slot_i,
   input logic              cl_err_o,
   input logic [NSLOT-1:0]  slot_busy,
   input logic [NSLOT-1:0]  wait_q,
   input logic              in_wait
);
   logic [NSLOT-1:0] cmp_hot;
   always_comb begin
      cmp_hot = '0;
      if (cmp_valid_i) cmp_hot[cmp_slot_i] = 1'b1;
   end

   // R6
   one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({iss_valid_o, commit_o, mem_req_valid_o}));

   // R3
   issue_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iss_valid_o) |-> commit_o);

   // R2
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid_o |-> !cl_ready_o);

   // R4
   dep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid_o && in_wait) |-> ((wait_q & slot_busy & ~cmp_hot) == '0));

   // R7
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid_o && !mem_req_ready_i) |=> mem_req_valid_o);

   // R8
   mem_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o |-> !slot_busy[mem_req_slot_o]);

   // R9
   reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cl_err_o |-> (!iss_valid_o && !commit_o && cl_ready_o));
endmodule

bind clause_seq clause_seq_chk #(
   .NSLOT  (NSLOT),
   .SLOT_W (SLOT_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cl_ready_o      (cl_ready_o),
   .iss_valid_o     (iss_valid_o),
   .commit_o        (commit_o),
   .mem_req_valid_o (mem_req_valid_o),
   .mem_req_ready_i (mem_req_ready_i),
   .mem_req_slot_o  (mem_req_slot_o),
   .cmp_valid_i     (cmp_valid_i),
   .cmp_slot_i      (cmp_slot_i),
   .cl_err_o        (cl_err_o),
   .slot_busy       (slot_busy),
   .wait_q          (wait_q),
   .in_wait         (state_q == clause_seq_pkg::ST_WAIT)
);

// File: tb/clause_seq_tb.sv
`timescale 1ns/1ps
module clause_seq_tb;
   localparam int NSLOT = 4, MAX_LEN = 8, INSTR_W = 32;
   localparam int SLOT_W = 2, LEN_W = 4;
   localparam int NCAP = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic                       cl_valid_i = 1'b0;
   logic                       cl_ready_o;
   logic [NSLOT-1:0]           cl_wait_i = '0;
   logic [LEN_W-1:0]           cl_len_i = '0;
   logic [MAX_LEN-1:0]         cl_varlat_i = '0;
   logic [SLOT_W-1:0]          cl_mem_slot_i = '0;
   logic [MAX_LEN*INSTR_W-1:0] cl_instr_i = '0;
   logic                       iss_valid_o;
   logic [INSTR_W-1:0]         iss_instr_o;
   logic                       commit_o;
   logic                       mem_req_valid_o;
   logic                       mem_req_ready_i = 1'b1;
   logic [INSTR_W-1:0]         mem_req_instr_o;
   logic [SLOT_W-1:0]          mem_req_slot_o;
   logic                       cmp_valid_i = 1'b0;
   logic [SLOT_W-1:0]          cmp_slot_i = '0;
   logic                       cl_err_o;

   clause_seq #(.NSLOT(NSLOT), .MAX_LEN(MAX_LEN), .INSTR_W(INSTR_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cl_valid_i(cl_valid_i), .cl_ready_o(cl_ready_o),
      .cl_wait_i(cl_wait_i), .cl_len_i(cl_len_i), .cl_varlat_i(cl_varlat_i),
      .cl_mem_slot_i(cl_mem_slot_i), .cl_instr_i(cl_instr_i),
      .iss_valid_o(iss_valid_o), .iss_instr_o(iss_instr_o),
      .commit_o(commit_o),
      .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
      .mem_req_instr_o(mem_req_instr_o), .mem_req_slot_o(mem_req_slot_o),
      .cmp_valid_i(cmp_valid_i), .cmp_slot_i(cmp_slot_i),
      .cl_err_o(cl_err_o)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic              cap_iss  [NCAP];
   logic [INSTR_W-1:0] cap_ins [NCAP];
   logic              cap_com  [NCAP];
   logic              cap_mem  [NCAP];
   logic [INSTR_W-1:0] cap_mins [NCAP];
   logic [SLOT_W-1:0] cap_mslot [NCAP];
   logic              cap_err  [NCAP];
   logic              cap_rdy  [NCAP];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [INSTR_W-1:0] word(input int c, input int i);
      return 32'hC000_0000 | (c << 8) | i;
   endfunction

   // Offer a clause at posedge+1; returns at posedge+1 just after the accept edge.
   task automatic send(input int c, input logic [NSLOT-1:0] w, input int len,
                       input logic [MAX_LEN-1:0] vl, input int slot);
      cl_wait_i     = w;
      cl_len_i      = LEN_W'(len);
      cl_varlat_i   = vl;
      cl_mem_slot_i = SLOT_W'(slot);
      for (int i = 0; i < MAX_LEN; i++) cl_instr_i[i*INSTR_W +: INSTR_W] = word(c, i);
      cl_valid_i = 1'b1;
      @(posedge clk);
      #1;
      cl_valid_i = 1'b0;
   endtask

   // Record n cycles; completion events a/b and ready low before rdy_cyc.
   task automatic capture(input int n, input int ca, input int sa,
                          input int cb, input int sb, input int rdy_cyc);
      for (int k = 0; k < n; k++) begin
         cmp_valid_i     = (k == ca) || (k == cb);
         cmp_slot_i      = (k == cb) ? SLOT_W'(sb) : SLOT_W'(sa);
         mem_req_ready_i = (k >= rdy_cyc);
         #1;
         cap_iss[k] = iss_valid_o;   cap_ins[k] = iss_instr_o;
         cap_com[k] = commit_o;      cap_mem[k] = mem_req_valid_o;
         cap_mins[k] = mem_req_instr_o; cap_mslot[k] = mem_req_slot_o;
         cap_err[k] = cl_err_o;      cap_rdy[k] = cl_ready_o;
         @(posedge clk);
         #1;
      end
      cmp_valid_i = 1'b0;
      mem_req_ready_i = 1'b1;
   endtask

   task automatic t_reset();
      chk("R1 ready", cl_ready_o, 1);
      chk("R1 issue", iss_valid_o, 0);
      chk("R1 commit", commit_o, 0);
      chk("R1 memreq", mem_req_valid_o, 0);
      chk("R1 err", cl_err_o, 0);
   endtask

   // 3 fixed + load on slot 0, no wait
   task automatic t_load_clause();
      send(1, 4'b0000, 4, 8'b0000_1000, 0);
      capture(7, -1, 0, -1, 0, 0);
      chk("R2 first issue cycle after accept", cap_iss[0], 1);
      chk("R2 ready low during clause", cap_rdy[1], 0);
      for (int i = 0; i < 3; i++) begin
         chk("R3 back to back", cap_iss[i], 1);
         chk("R3 issue order", cap_ins[i], word(1, i));
      end
      chk("R6 commit after last fixed", cap_com[3], 1);
      chk("R6 no early commit", cap_com[2], 0);
      chk("R7 mem req after commit", cap_mem[4], 1);
      chk("R7 mem instr", cap_mins[4], word(1, 3));
      chk("R7 mem slot", cap_mslot[4], 0);
      chk("R6 single commit", cap_com[4], 0);
      chk("R2 ready after clause", cap_rdy[5], 1);
   endtask

   // waits on slot 0 (busy); completion at cycle 3
   task automatic t_wait_release();
      send(2, 4'b0001, 2, 8'b0, 0);
      capture(7, 3, 0, -1, 0, 0);
      for (int i = 0; i < 3; i++) chk("R4 held while slot busy", cap_iss[i], 0);
      chk("R5 same-cycle release", cap_iss[3], 1);
      chk("R5 first instr", cap_ins[3], word(2, 0));
      chk("R3 second instr", cap_ins[4], word(2, 1));
      chk("R6 commit", cap_com[5], 1);
      chk("R7 no mem req without flag", cap_mem[6], 0);
   endtask

   task automatic t_reject();
      send(3, 4'b0000, 2, 8'b0000_0001, 0);
      capture(3, -1, 0, -1, 0, 0);
      chk("R9 err pulse", cap_err[0], 1);
      chk("R9 ready at once", cap_rdy[0], 1);
      chk("R9 err one cycle", cap_err[1], 0);
      chk("R9 no issue", cap_iss[0] | cap_iss[1] | cap_com[1] | cap_mem[2], 0);
      send(4, 4'b0000, 0, 8'b0, 0);
      capture(2, -1, 0, -1, 0, 0);
      chk("R9 zero length err", cap_err[0], 1);
      chk("R9 zero length no issue", cap_iss[0] | cap_com[1], 0);
   endtask

   // store-only clause on slot 1, ready low until cycle 3
   task automatic t_store_bp();
      send(5, 4'b0000, 1, 8'b0000_0001, 1);
      capture(6, -1, 0, -1, 0, 3);
      chk("R6 mem-only commit", cap_com[1], 1);
      chk("R6 mem-only no issue", cap_iss[0], 0);
      chk("R7 req under backpressure", cap_mem[2], 1);
      chk("R7 req held", cap_mem[3], 1);
      chk("R7 req slot", cap_mslot[2], 1);
      chk("R7 req instr", cap_mins[2], word(5, 0));
      chk("R7 req dropped after accept", cap_mem[4], 0);
   endtask

   // wait mask names only idle slot 2
   task automatic t_idle_mask();
      send(6, 4'b0100, 1, 8'b0, 0);
      capture(3, -1, 0, -1, 0, 0);
      chk("R4 idle slot no delay", cap_iss[0], 1);
      chk("R6 commit", cap_com[1], 1);
   endtask

   // slot 1 still busy: store on slot 1 waits for completion at cycle 3
   task automatic t_slot_reuse();
      send(7, 4'b0000, 1, 8'b0000_0001, 1);
      capture(6, 3, 1, -1, 0, 0);
      chk("R8 held at 2", cap_mem[2], 0);
      chk("R8 held at 3", cap_mem[3], 0);
      chk("R8 rises after completion", cap_mem[4], 1);
      chk("R8 gone after accept", cap_mem[5], 0);
   endtask

   // slot 1 busy again: unrelated slot 3 completes at 1, slot 1 at 4
   task automatic t_other_slot();
      send(8, 4'b0010, 1, 8'b0, 0);
      capture(7, 1, 3, 4, 1, 0);
      for (int i = 0; i < 4; i++) chk("R4 other slot no release", cap_iss[i], 0);
      chk("R5 release on own slot", cap_iss[4], 1);
      chk("R6 commit", cap_com[5], 1);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset();
      t_load_clause();
      t_wait_release();
      t_reject();
      t_store_bp();
      t_idle_mask();
      t_slot_reuse();
      t_other_slot();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule